// File: doc/BRIEF.md
# EEPROM Page Write and Busy Engine

This block sits behind the command decoder of a serial EEPROM model. A write transaction arrives as a start address followed by a run of whole data bytes. The bytes are gathered in a small page buffer, and the buffer walks only the low address bits, so bytes beyond the page size wrap back and replace earlier ones. When chip select rises cleanly after a whole byte, a self-timed programming cycle runs. It copies every received slot into the register array and keeps `busy` high for a fixed, parameterised number of cycles. On completion it issues a one-cycle pulse that clears the write-enable latch.

Reads share the array read port. A read start loads an address pointer, and each byte-advance strobe moves the pointer up by one, wrapping from the top of the array to zero. Opcode decoding, the write-enable latch itself and block protection live outside this block. Write-protect is seen here only as a level that can abandon a transaction that is still being collected.

Top module: `eep_page_prog`

## Requirements
- R1: Each received byte goes to the next page slot. Only the low log2(PAGE_BYTES) address bits advance, and they wrap, so with 8-byte pages the 9th byte replaces the 1st; the upper address bits stay those of the start address.
- R2: Programming starts only when `cs_rise` is sampled while a transaction is collecting, with `part_bits` low, `wp_n` high and at least one whole byte received; `busy` is high in the cycle after that edge.
- R3: `busy` stays high for exactly WC_CYCLES clock cycles per programming cycle, whatever `wp_n` does meanwhile.
- R4: `wel_clr` is high for exactly one cycle, the cycle right after `busy` falls.
- R5: `rd_data` shows the array byte at the read pointer. `rd_begin` loads the pointer from `start_addr`, `rd_next` adds one, and the pointer wraps from the highest address to 0.
- R6: `wp_n` low while a transaction is collecting abandons it: no busy, array unchanged.
- R7: Page locations that received no byte keep their previous contents.
- R8: A `cs_rise` with `part_bits` high, or with no whole byte received, discards the transaction: no busy, array unchanged.
- R9: After reset every array byte is 0xFF, `busy` and `wel_clr` are low and the read pointer is 0.
- R10: While `busy` is high, `wr_begin`, `byte_vld`, `cs_rise`, `rd_begin` and `rd_next` have no effect.
- R11: In a programming cycle `arr_we` is high for exactly one cycle per distinct page slot received, all inside the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin | input | 1 | Start a write transaction at `start_addr` |
| rd_begin | input | 1 | Load the read pointer from `start_addr` |
| start_addr | input | ADDR_W | Start address for write or read |
| byte_vld | input | 1 | A whole data byte has been received |
| byte_data | input | DATA_W | The received data byte |
| part_bits | input | 1 | Some bits of an unfinished byte were shifted in |
| cs_rise | input | 1 | Chip select has risen (end of transaction) |
| wp_n | input | 1 | Write-protect level, low abandons collection |
| rd_next | input | 1 | Advance the read pointer by one |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | One-cycle pulse at the end of programming |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| rd_data | output | DATA_W | Array byte at the read pointer |

## Verification
A wrong page pointer or valid mask shows up as misplaced or missing bytes. Readback after the cycle ends exposes them, and so does the number of `arr_we` strobes, which is visible within the first PAGE_BYTES cycles of `busy`. A timer that is off by one changes the length of `busy` and shifts `wel_clr` by a cycle, which shows at the end of each programming cycle. Commit or abort logic that ignores `part_bits`, `wp_n` or `busy` shows as `busy` rising, or failing to rise, one cycle after the ending strobe. A read pointer that does not wrap shows in the first byte read after the top address.

// File: rtl/eep_prog_pkg.sv
package eep_prog_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } eep_txn_state_e;
endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8,
   localparam int PG_W      = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [PG_W-1:0]   start_off,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [PG_W-1:0]   rd_slot,
   output logic [DATA_W-1:0] slot_data,
   output logic              slot_valid,
   output logic              any_valid
);
   logic [DATA_W-1:0]     slots [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid;
   logic [PG_W-1:0]       wptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         wptr  <= '0;
      end else if (clear) begin
         valid <= '0;
         wptr  <= start_off;
      end else if (push) begin
         valid[wptr] <= 1'b1;
         wptr        <= wptr + 1'b1;
      end
   end

   generate
      for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slots[s] <= '0;
            else if (push && !clear && wptr == PG_W'(s))
               slots[s] <= push_data;
         end
      end
   endgenerate

   assign slot_data  = slots[rd_slot];
   assign slot_valid = valid[rd_slot];
   assign any_valid  = |valid;

   // R1: the slot pointer moves through the page modulo its size
   p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clear) |=> valid[$past(wptr)]);
endmodule

// File: rtl/eep_wc_timer.sv
module eep_wc_timer #(
   parameter int WC_CYCLES = 2000,
   localparam int CNT_W    = $clog2(WC_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WC_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (run) begin
         if (cnt == LAST_CNT) begin
            run <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (start) begin
         run <= 1'b1;
         cnt <= '0;
      end
   end

   assign last = run && (cnt == LAST_CNT);

   // R3: busy is held until the final count
   p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !last) |=> run);
   // R10: a new cycle is never requested while one runs
   p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run);
endmodule

// File: rtl/eep_reg_array.sv
module eep_reg_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cells[w] <= '1;
            else if (we && waddr == ADDR_W'(w))
               cells[w] <= wdata;
         end
      end
   endgenerate

   assign rdata = cells[raddr];
endmodule

// File: rtl/eep_page_prog.sv
module eep_page_prog
   import eep_prog_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8,
   parameter int WC_CYCLES  = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_begin,
   input  logic              rd_begin,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              part_bits,
   input  logic              cs_rise,
   input  logic              wp_n,
   input  logic              rd_next,
   output logic              busy,
   output logic              wel_clr,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_waddr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PG_W  = $clog2(PAGE_BYTES);
   localparam int CNT_W = $clog2(WC_CYCLES);
   localparam int BASE_W = ADDR_W - PG_W;
   localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0)
         $error("PAGE_BYTES must be a power of two of at least 2");
      if (WC_CYCLES <= PAGE_BYTES)
         $error("WC_CYCLES must exceed PAGE_BYTES");
      if (ADDR_W <= PG_W)
         $error("ADDR_W must be wider than the page offset");
   endgenerate

   eep_txn_state_e    state;
   logic [BASE_W-1:0] base;
   logic [ADDR_W-1:0] rd_addr;
   logic              buf_clear, buf_push, commit;
   logic              slot_valid, any_valid, tmr_last;
   logic [CNT_W-1:0]  tmr_cnt;
   logic [DATA_W-1:0] slot_data;

   assign buf_clear = wr_begin && !busy;
   assign buf_push  = (state == ST_FILL) && byte_vld && wp_n && !cs_rise;
   assign commit    = (state == ST_FILL) && cs_rise && wp_n && !part_bits && any_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         base  <= '0;
      end else if (busy) begin
         state <= ST_IDLE;
      end else if (state == ST_FILL && (!wp_n || cs_rise)) begin
         state <= ST_IDLE;
      end else if (wr_begin) begin
         state <= ST_FILL;
         base  <= start_addr[ADDR_W-1:PG_W];
      end
   end

   eep_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .clear(buf_clear), .start_off(start_addr[PG_W-1:0]),
      .push(buf_push), .push_data(byte_data),
      .rd_slot(tmr_cnt[PG_W-1:0]), .slot_data(slot_data),
      .slot_valid(slot_valid), .any_valid(any_valid)
   );

   eep_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(commit),
      .run(busy), .cnt(tmr_cnt), .last(tmr_last)
   );

   assign arr_we    = busy && (tmr_cnt < PAGE_CNT) && slot_valid;
   assign arr_waddr = {base, tmr_cnt[PG_W-1:0]};
   assign arr_wdata = slot_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wel_clr <= 1'b0;
      else        wel_clr <= tmr_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_addr <= '0;
      else if (!busy) begin
         if (rd_begin)     rd_addr <= start_addr;
         else if (rd_next) rd_addr <= rd_addr + 1'b1;
      end
   end

   eep_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
      .raddr(rd_addr), .rdata(rd_data)
   );

   // R1: all writes of one cycle stay inside one page
   p_same_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |-> $stable(arr_waddr[ADDR_W-1:PG_W]));
   // R4: completion pulse follows the fall of busy and lasts one cycle
   p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> wel_clr);
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |=> !wel_clr);
   // R5: read pointer advance wraps modulo the array size
   p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_next && !rd_begin) |=> rd_addr == $past(rd_addr) + 1'b1);
   // R6: write-protect during collection prevents programming
   p_wp_abandon_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && !wp_n && !busy) |=> !busy);
   // R8: an unfinished byte at chip-select rise prevents programming
   p_partial_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && cs_rise && part_bits && !busy) |=> !busy);
   // R11: array writes only occur inside the busy window
   p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy && !wel_clr);
endmodule

// File: tb/test_eep_page_prog.sv
module test_eep_page_prog;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int WC = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_begin = 1'b0, rd_begin = 1'b0, byte_vld = 1'b0;
   logic          part_bits = 1'b0, cs_rise = 1'b0, wp_n = 1'b1, rd_next = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [DW-1:0] byte_data = '0;
   logic          busy, wel_clr, arr_we;
   logic [AW-1:0] arr_waddr;
   logic [DW-1:0] arr_wdata, rd_data;

   int total = 0;
   int bad = 0;
   logic [7:0] exp_mem [256];
   logic [7:0] tx [16];

   always #4 clk = ~clk;

   eep_page_prog #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(8), .WC_CYCLES(WC)) i_eep_page_prog (
      .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .rd_begin(rd_begin),
      .start_addr(start_addr), .byte_vld(byte_vld), .byte_data(byte_data),
      .part_bits(part_bits), .cs_rise(cs_rise), .wp_n(wp_n), .rd_next(rd_next),
      .busy(busy), .wel_clr(wel_clr), .arr_we(arr_we), .arr_waddr(arr_waddr),
      .arr_wdata(arr_wdata), .rd_data(rd_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd_check(input logic [7:0] a, input string req);
      start_addr = a; rd_begin = 1'b1;
      @(negedge clk); rd_begin = 1'b0;
      chk(req, rd_data, exp_mem[a]);
   endtask

   // drives a write transaction; returns whether it should commit
   task automatic send_write(input logic [7:0] a, input int n, input bit part,
                             input bit drop_wp, output bit will_commit);
      start_addr = a; wr_begin = 1'b1;
      @(negedge clk); wr_begin = 1'b0;
      for (int i = 0; i < n; i++) begin
         byte_data = tx[i]; byte_vld = 1'b1;
         @(negedge clk); byte_vld = 1'b0;
      end
      if (drop_wp) begin wp_n = 1'b0; @(negedge clk); end
      part_bits = part; cs_rise = 1'b1;
      @(negedge clk); cs_rise = 1'b0; part_bits = 1'b0; wp_n = 1'b1;
      will_commit = (n > 0) && !part && !drop_wp;
      if (will_commit)
         for (int i = 0; i < n; i++)
            exp_mem[{a[7:3], 3'(a[2:0] + 3'(i))}] = tx[i];
   endtask

   task automatic wait_idle(input int n0, input int w0, input int exp_we);
      int n = n0;
      int w = w0;
      while (busy) begin
         if (arr_we) w++;
         n++;
         @(negedge clk);
      end
      chk("R3 busy length", n, WC);
      chk("R11 write strobes", w, exp_we);
      chk("R4 wel_clr after busy", wel_clr, 1);
      @(negedge clk);
      chk("R4 wel_clr single", wel_clr, 0);
   endtask

   task automatic t_reset;
      chk("R9 busy at reset", busy, 0);
      chk("R9 wel_clr at reset", wel_clr, 0);
      chk("R9 read pointer 0", rd_data, 8'hFF);
      rd_check(8'hAB, "R9 array FF");
   endtask

   task automatic t_single;
      bit c;
      tx[0] = 8'h5A;
      send_write(8'h13, 1, 1'b0, 1'b0, c);
      chk("R2 busy after commit", busy, 1);
      wait_idle(0, 0, 1);
      rd_check(8'h13, "R2 data written");
      rd_check(8'h12, "R7 neighbour below");
      rd_check(8'h14, "R7 neighbour above");
   endtask

   task automatic t_page_wrap;
      bit c;
      for (int i = 0; i < 10; i++) tx[i] = 8'h30 + 8'(i);
      send_write(8'h2E, 10, 1'b0, 1'b0, c);
      chk("R2 busy after page write", busy, 1);
      wait_idle(0, 0, 8);
      for (int a = 8'h28; a < 8'h30; a++) rd_check(8'(a), "R1 page wrap");
      chk("R1 ninth byte replaced first", exp_mem[8'h2E], 8'h38);
      rd_check(8'h30, "R1 next page untouched");
   endtask

   task automatic t_partial;
      bit c;
      tx[0] = 8'hC1; tx[1] = 8'hC2;
      send_write(8'h50, 2, 1'b1, 1'b0, c);
      chk("R8 partial byte no busy", busy, 0);
      @(negedge clk);
      chk("R8 partial byte no busy later", busy, 0);
      rd_check(8'h50, "R8 partial byte array unchanged");
      send_write(8'h51, 0, 1'b0, 1'b0, c);
      chk("R8 address only no busy", busy, 0);
      rd_check(8'h51, "R8 address only array unchanged");
   endtask

   task automatic t_wp;
      bit c;
      tx[0] = 8'h66;
      send_write(8'h60, 1, 1'b0, 1'b1, c);
      chk("R6 wp abandon no busy", busy, 0);
      rd_check(8'h60, "R6 wp abandon array unchanged");
      tx[0] = 8'h77;
      send_write(8'h61, 1, 1'b0, 1'b0, c);
      chk("R6 busy before wp drop", busy, 1);
      wp_n = 1'b0;
      wait_idle(0, 0, 1);
      wp_n = 1'b1;
      rd_check(8'h61, "R6 wp during busy no effect");
   endtask

   task automatic t_busy_ignore;
      bit c;
      int n = 0;
      int w = 0;
      rd_check(8'h13, "R10 setup pointer");
      tx[0] = 8'h11;
      send_write(8'h70, 1, 1'b0, 1'b0, c);
      chk("R10 busy running", busy, 1);
      for (int k = 0; k < 5; k++) begin
         if (busy) n++;
         if (arr_we) w++;
         start_addr = (k == 0) ? 8'h80 : 8'h70;
         rd_begin = (k == 0); rd_next = (k == 1);
         wr_begin = (k == 2); byte_vld = (k == 3); byte_data = 8'h99;
         cs_rise = (k == 4);
         @(negedge clk);
      end
      rd_begin = 1'b0; rd_next = 1'b0; wr_begin = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0;
      wait_idle(n, w, 1);
      chk("R10 no restart", busy, 0);
      chk("R10 read pointer kept", rd_data, exp_mem[8'h13]);
      rd_check(8'h70, "R10 ignored byte not stored");
   endtask

   task automatic t_read_wrap;
      bit c;
      tx[0] = 8'hAA; tx[1] = 8'hBB;
      send_write(8'hFE, 2, 1'b0, 1'b0, c);
      wait_idle(0, 0, 2);
      rd_check(8'hFE, "R5 read start");
      rd_next = 1'b1; @(negedge clk); rd_next = 1'b0;
      chk("R5 read increment", rd_data, 8'hBB);
      rd_next = 1'b1; @(negedge clk); rd_next = 1'b0;
      chk("R5 read wrap to 0", rd_data, exp_mem[8'h00]);
      rd_next = 1'b1; @(negedge clk); rd_next = 1'b0;
      chk("R5 read after wrap", rd_data, exp_mem[8'h01]);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_page_wrap();
      t_partial();
      t_wp();
      t_busy_ignore();
      t_read_wrap();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule